// File: doc/BRIEF.md
# SPI Slave Control Port

This block connects an external host that acts as SPI master (mode 0, most significant bit first, 8-bit bytes) to a byte-wide on-chip interface. Bytes the host shifts in are gathered into a receive FIFO. An on-chip consumer drains that FIFO with a valid/ready handshake. Bytes an on-chip producer queues in a transmit FIFO are shifted back to the host on MISO.

All serial pins are brought into the system clock domain through a two-flop synchroniser and edge-detected there. The system clock must therefore run at least four times faster than the serial clock.

Two handshake lines go back to the host:
- An active-low busy output throttles the host before the receive FIFO can overflow.
- An interrupt output tells the host that reply data is waiting. It rises on a serial clock falling edge and drops when chip select is released at the end of the transfer that carried the queued data out.

Top module: `spi_ctl_port`

## Requirements
- R1: While chip select is low, MOSI is sampled on each rising serial clock edge. Each group of 8 bits, most significant bit first, becomes one byte. The bytes are offered on rx_data_o/rx_valid_o in arrival order, and a byte is removed in each cycle where rx_valid_o and rx_ready_i are both high.
- R2: The most significant bit of the outgoing byte is on spi_miso_o after chip select falls and before the first rising edge. Later bits change only after falling serial clock edges.
- R3: When no transmit byte is queued at a byte boundary, that byte is shifted out as 0x00.
- R4: spi_busy_no is low exactly while the receive FIFO (16 entries) holds 14 or more bytes. It goes low no later than 3 system clock cycles after the rising serial clock edge that completes the 14th byte.
- R5: A byte completed while the receive FIFO is full is dropped, and the stored bytes are kept unchanged.
- R6: spi_irq_o rises only after a falling serial clock edge during a transfer. It rises when the transmit queue is non-empty or when a queued byte has already been shifted out in that transfer. It stays low when neither is true.
- R7: spi_irq_o falls when chip select rises at the end of a transfer that shifted out at least one queued byte. Otherwise it holds its value across the chip select rise.
- R8: spi_miso_oe_o is high only while the synchronised chip select is low. MISO is in high impedance while chip select is high.
- R9: A chip select rise in the middle of a byte discards the partial bits. The next transfer starts a new byte at bit 7.
- R10: A queued transmit byte is removed only at the first rising edge of the byte that carries it out. A transfer that ends before that edge leaves the byte queued.
- R11: tx_ready_o is low while the transmit FIFO (4 entries) is full, and a byte offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_ni | input | 1 | Chip select from host, active low |
| spi_sclk_i | input | 1 | Serial clock from host |
| spi_mosi_i | input | 1 | Serial data from host |
| spi_miso_o | output | 1 | Serial data to host |
| spi_miso_oe_o | output | 1 | MISO pad driver enable |
| spi_busy_no | output | 1 | Receive throttle to host, active low |
| spi_irq_o | output | 1 | Reply-pending interrupt to host |
| rx_data_o | output | 8 | Oldest received byte |
| rx_valid_o | output | 1 | Receive FIFO not empty |
| rx_ready_i | input | 1 | Consumer takes rx_data_o |
| tx_data_i | input | 8 | Byte to queue for the host |
| tx_valid_i | input | 1 | tx_data_i is offered |
| tx_ready_o | output | 1 | Transmit FIFO can accept a byte |

## Verification
A serial byte can complete in the same system clock cycle in which the consumer pops the receive FIFO. When the FIFO sits at the busy threshold, that coincidence must leave the level, and so the busy output, unchanged. The bench provokes it by filling the FIFO to 14 bytes and then completing another byte. It raises rx_ready_i for exactly the one cycle in which the synchronised rising edge is acted on. It judges the result in three ways: busy must stay asserted, the later drain must return exactly the expected 16 bytes in order, and a byte sent into the full FIFO must be missing from that drain.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/spi_ctl_sync.sv
module spi_ctl_sync #(
  parameter int             STAGES  = 2,
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/spi_ctl_fifo.sv
module spi_ctl_fifo #(
  parameter int  DEPTH = 16,
  parameter int  W     = 8,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic [LW-1:0] level_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic          do_push, do_pop;

  // push into a full FIFO and pop from an empty one are dropped here
  assign do_push = push_i && (level_o != LW'(DEPTH));
  assign do_pop  = pop_i  && (level_o != '0);

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_o <= '0;
    end else begin
      if (do_push) wr_q <= ptr_inc(wr_q);
      if (do_pop)  rd_q <= ptr_inc(rd_q);
      case ({do_push, do_pop})
        2'b10:   level_o <= level_o + 1'b1;
        2'b01:   level_o <= level_o - 1'b1;
        default: level_o <= level_o;
      endcase
    end
  end

  assign data_o = mem_q[rd_q];
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter int  RX_DEPTH    = 16,
  parameter int  TX_DEPTH    = 4,
  parameter int  BUSY_FREE   = 2,
  parameter int  SYNC_STAGES = 2,
  localparam int RX_LW       = $clog2(RX_DEPTH + 1),
  localparam int TX_LW       = $clog2(TX_DEPTH + 1),
  localparam int BUSY_LVL    = RX_DEPTH - BUSY_FREE,
  localparam int BIT_CW      = $clog2(BYTE_W)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        spi_cs_ni,
  input  logic        spi_sclk_i,
  input  logic        spi_mosi_i,
  output logic        spi_miso_o,
  output logic        spi_miso_oe_o,
  output logic        spi_busy_no,
  output logic        spi_irq_o,
  output logic [7:0]  rx_data_o,
  output logic        rx_valid_o,
  input  logic        rx_ready_i,
  input  logic [7:0]  tx_data_i,
  input  logic        tx_valid_i,
  output logic        tx_ready_o
);
  logic              cs_s, sclk_s, mosi_s, cs_d, sclk_d;
  logic              sel, sclk_rise, sclk_fall, cs_fall, cs_rise;
  logic [BIT_CW-1:0] bit_cnt_q;
  logic [BYTE_W-2:0] rx_sh_q;
  logic              byte_done, at_boundary;
  byte_t             rx_word, tx_head, tx_sh_q;
  logic [RX_LW-1:0]  rx_level;
  logic [TX_LW-1:0]  tx_level;
  logic              rx_full, tx_empty, tx_pop, tx_armed_q, popped_q, irq_q;

  spi_ctl_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({spi_cs_ni, spi_sclk_i, spi_mosi_i}),
    .q_o    ({cs_s, sclk_s, mosi_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign sel       = !cs_s;
  assign sclk_rise = sel && sclk_s && !sclk_d;
  assign sclk_fall = sel && !sclk_s && sclk_d;
  assign cs_fall   = !cs_s && cs_d;
  assign cs_rise   = cs_s && !cs_d;

  // receive shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      rx_sh_q   <= '0;
    end else if (!sel) begin
      bit_cnt_q <= '0;
    end else if (sclk_rise) begin
      rx_sh_q   <= rx_word[BYTE_W-2:0];
      bit_cnt_q <= (bit_cnt_q == BIT_CW'(BYTE_W - 1)) ? '0 : bit_cnt_q + 1'b1;
    end
  end

  assign rx_word     = {rx_sh_q, mosi_s};
  assign byte_done   = sclk_rise && (bit_cnt_q == BIT_CW'(BYTE_W - 1));
  assign at_boundary = bit_cnt_q == '0;

  spi_ctl_fifo #(.DEPTH(RX_DEPTH), .W(BYTE_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (byte_done),
    .data_i  (rx_word),
    .pop_i   (rx_ready_i && rx_valid_o),
    .data_o  (rx_data_o),
    .level_o (rx_level)
  );

  assign rx_valid_o  = rx_level != '0;
  assign rx_full     = rx_level == RX_LW'(RX_DEPTH);
  assign spi_busy_no = rx_level < RX_LW'(BUSY_LVL);

  spi_ctl_fifo #(.DEPTH(TX_DEPTH), .W(BYTE_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (tx_valid_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop),
    .data_o  (tx_head),
    .level_o (tx_level)
  );

  assign tx_empty   = tx_level == '0;
  assign tx_ready_o = tx_level != TX_LW'(TX_DEPTH);

  // transmit: stage the head at a slot, consume it at the byte's first rise
  assign tx_pop = sclk_rise && at_boundary && tx_armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q    <= '0;
      tx_armed_q <= 1'b0;
    end else if (!sel) begin
      tx_armed_q <= 1'b0;
    end else if (cs_fall || (sclk_fall && at_boundary)) begin
      tx_sh_q    <= tx_empty ? '0 : tx_head;
      tx_armed_q <= !tx_empty;
    end else if (sclk_fall) begin
      tx_sh_q    <= {tx_sh_q[BYTE_W-2:0], 1'b0};
    end else if (tx_pop) begin
      tx_armed_q <= 1'b0;
    end
  end

  assign spi_miso_o    = tx_sh_q[BYTE_W-1];
  assign spi_miso_oe_o = sel;

  // reply interrupt
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q    <= 1'b0;
      popped_q <= 1'b0;
    end else if (cs_rise) begin
      popped_q <= 1'b0;
      if (popped_q) irq_q <= 1'b0;
    end else begin
      if (tx_pop) popped_q <= 1'b1;
      if (sclk_fall && (!tx_empty || popped_q)) irq_q <= 1'b1;
    end
  end

  assign spi_irq_o = irq_q;
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spi_cs_ni,
  input logic spi_miso_oe_o,
  input logic spi_busy_no,
  input logic spi_irq_o,
  input logic rx_full,
  input logic sclk_fall,
  input logic cs_rise,
  input logic tx_pop,
  input logic tx_empty
);
  AST_MISO_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(spi_cs_ni, 2) |-> !spi_miso_oe_o); // R8

  AST_FULL_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full |-> !spi_busy_no); // R4

  AST_IRQ_SET_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spi_irq_o) |-> $past(sclk_fall)); // R6

  AST_IRQ_CLR_ON_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_irq_o) |-> $past(cs_rise)); // R7

  AST_NO_TX_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_pop |-> !tx_empty); // R10
endmodule

bind spi_ctl_port spi_ctl_port_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .spi_cs_ni     (spi_cs_ni),
  .spi_miso_oe_o (spi_miso_oe_o),
  .spi_busy_no   (spi_busy_no),
  .spi_irq_o     (spi_irq_o),
  .rx_full       (rx_full),
  .sclk_fall     (sclk_fall),
  .cs_rise       (cs_rise),
  .tx_pop        (tx_pop),
  .tx_empty      (tx_empty)
);

// File: tb/tb_spi_ctl_port.sv
module tb_spi_ctl_port;
  import spi_ctl_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic  clk = 0, rst_n = 0;
  logic  cs_n = 1, sclk = 0, mosi = 0, rx_ready = 0, tx_valid = 0;
  byte_t tx_data = '0;
  logic  miso, miso_oe, busy_n, irq, rx_valid, tx_ready;
  byte_t rx_data, got;
  int    n_chk = 0, n_err = 0;
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_ctl_port dut (
    .clk_i(clk), .rst_ni(rst_n), .spi_cs_ni(cs_n), .spi_sclk_i(sclk), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe), .spi_busy_no(busy_n), .spi_irq_o(irq),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (4) @(negedge clk); cs_n = 1;
    repeat (HALF) @(negedge clk);
  endtask

  // mode 1: pulse rx_ready in the cycle the last rise is acted on; mode 2: check busy 3 clocks after last rise
  task automatic shift(input int nbits, input byte_t mo, output byte_t mi, input int mode);
    mi = '0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[7-i];
      repeat (HALF) @(negedge clk);
      mi[7-i] = miso;
      sclk = 1;
      if (i == nbits-1 && mode == 1) begin
        repeat (2) @(negedge clk); rx_ready = 1;
        @(negedge clk); rx_ready = 0;
        repeat (HALF-3) @(negedge clk);
      end else if (i == nbits-1 && mode == 2) begin
        repeat (3) @(negedge clk);
        chk("R4", "busy 3 clocks after 14th byte", busy_n, 0);
        repeat (HALF-3) @(negedge clk);
      end else begin
        repeat (HALF) @(negedge clk);
      end
      sclk = 0;
    end
  endtask

  task automatic take(input string req, input byte_t exp);
    chk(req, "rx_valid", rx_valid, 1);
    chk(req, "rx_data", rx_data, exp);
    rx_ready = 1; @(negedge clk); rx_ready = 0;
  endtask

  task automatic put(input byte_t d);
    tx_valid = 1; tx_data = d; @(negedge clk); tx_valid = 0;
  endtask

  task automatic t_reset();
    chk("R8", "oe after reset", miso_oe, 0);
    chk("R4", "busy after reset", busy_n, 1);
    chk("R6", "irq after reset", irq, 0);
    chk("R1", "rx_valid after reset", rx_valid, 0);
    chk("R11", "tx_ready after reset", tx_ready, 1);
  endtask

  task automatic t_rx_basic();
    sel();
    shift(8, 8'hA5, got, 0); chk("R3", "idle reply", got, 8'h00);
    shift(8, 8'h3C, got, 0);
    chk("R6", "irq with empty queue", irq, 0);
    desel();
    take("R1", 8'hA5); take("R1", 8'h3C);
    chk("R1", "rx drained", rx_valid, 0);
  endtask

  task automatic t_tx_basic();
    put(8'h96);
    sel();
    chk("R8", "oe while selected", miso_oe, 1);
    chk("R2", "msb before first rise", miso, 1);
    shift(8, 8'h11, got, 0); chk("R2", "reply byte", got, 8'h96);
    chk("R6", "irq after reply shifted", irq, 1);
    shift(8, 8'h22, got, 0); chk("R3", "reply on empty queue", got, 8'h00);
    desel();
    chk("R7", "irq after cs release", irq, 0);
    chk("R8", "oe after cs release", miso_oe, 0);
    take("R1", 8'h11); take("R1", 8'h22);
  endtask

  task automatic t_irq_hold();
    sel();
    put(8'h5A);
    shift(8, 8'h44, got, 0); chk("R3", "queued after slot", got, 8'h00);
    chk("R6", "irq with queued byte", irq, 1);
    desel();
    chk("R7", "irq held, nothing shifted", irq, 1);
    sel();
    shift(8, 8'h55, got, 0); chk("R10", "byte kept queued", got, 8'h5A);
    desel();
    chk("R7", "irq after read transfer", irq, 0);
    take("R1", 8'h44); take("R1", 8'h55);
  endtask

  task automatic t_abort();
    put(8'h77);
    sel(); desel();
    sel();
    shift(8, 8'hC3, got, 0); chk("R10", "byte survives empty transfer", got, 8'h77);
    desel();
    sel(); shift(3, 8'hA0, got, 0); desel();
    chk("R9", "partial byte not stored", rx_valid, 1);
    sel(); shift(8, 8'h3E, got, 0); desel();
    take("R9", 8'hC3); take("R9", 8'h3E);
    chk("R9", "no extra byte", rx_valid, 0);
  endtask

  task automatic t_busy();
    sel();
    for (int k = 0; k < 13; k++) shift(8, byte_t'(8'h10 + k), got, 0);
    chk("R4", "busy at 13 bytes", busy_n, 1);
    shift(8, 8'h1D, got, 2);
    shift(8, 8'h1E, got, 1);
    chk("R4", "busy after push+pop at 14", busy_n, 0);
    shift(8, 8'h1F, got, 0);
    shift(8, 8'h20, got, 0);
    shift(8, 8'h21, got, 0);
    desel();
    chk("R4", "busy when full", busy_n, 0);
    for (int k = 1; k <= 16; k++) begin
      take("R5", byte_t'(8'h10 + k));
      if (k == 2) chk("R4", "busy at 14", busy_n, 0);
      if (k == 3) chk("R4", "busy released at 13", busy_n, 1);
    end
    chk("R5", "overflow byte dropped", rx_valid, 0);
  endtask

  task automatic t_tx_full();
    for (int k = 0; k < 4; k++) put(byte_t'(8'hA1 + k));
    chk("R11", "tx_ready when full", tx_ready, 0);
    put(8'hEE);
    sel();
    for (int k = 0; k < 4; k++) begin
      shift(8, 8'h00, got, 0);
      chk("R11", "queued reply", got, byte_t'(8'hA1 + k));
    end
    chk("R6", "irq during reply burst", irq, 1);
    shift(8, 8'h00, got, 0); chk("R11", "byte offered when full ignored", got, 8'h00);
    desel();
    chk("R7", "irq after burst", irq, 0);
    chk("R11", "tx_ready after drain", tx_ready, 1);
    for (int k = 0; k < 5; k++) take("R1", 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_irq_hold();
    t_abort();
    t_busy();
    t_tx_full();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule